// File: doc/BRIEF.md
# Return-to-Zero Serial Word Transmitter

The block takes 32-bit words one at a time from a synchronous FIFO with registered read data. It sends each word bit by bit over a pair of complementary return-to-zero lines. A single system clock drives all of the logic. Bit timing comes from a counter that marks the end of every bit period, so the block generates no second clock. Two bit rates are available, and the rate is fixed when a word is loaded.

Each word is reordered before it is sent. The low label field goes out most significant bit first. The remaining bits follow in ascending order. Parity can optionally replace the top bit. After the last bit both lines stay low for a quiet gap of either a short or a long number of bit times. Only then does the block ask the FIFO for another word.

Top module: `rz_word_tx`

## Requirements
- R1: While `rst_i` is high and on the first cycle after it falls, `fifo_rd_o`, `line_a_o`, `line_b_o` and `busy_o` are all 0.
- R2: For each word, `fifo_rd_o` is high for exactly one cycle, and exactly one word is taken from the FIFO. No further strobe is issued until that word's gap has ended.
- R3: While `en_i` is 0 or `fifo_empty_i` is 1, no strobe is issued and both lines stay low.
- R4: Bits of the word are sent in this order: bits LABEL_W-1 down to 0 first, then bits LABEL_W up to WORD_W-1 in ascending order. The first bit period starts two cycles after the strobe cycle.
- R5: In the first half of each bit period (DIV/2 cycles), `line_a_o` equals the bit and `line_b_o` equals its complement. In the second half both lines are 0.
- R6: A bit period lasts FAST_DIV cycles when `fast_i` is 1 and SLOW_DIV cycles when it is 0. The value is taken in the cycle after the strobe, so a later change of `fast_i` does not affect a word already in progress.
- R7: When `par_en_i` is 1, the top bit is replaced by parity computed over bits 0 to WORD_W-2. With `par_odd_i`=1 the word sent has an odd number of ones, and with 0 it has an even number.
- R8: When `par_en_i` is 0, the top bit is sent exactly as it was read from the FIFO.
- R9: After the last bit, both lines stay low for SHORT_GAP bit periods if `short_gap_i` was 1 at load, and for LONG_GAP bit periods otherwise.
- R10: `busy_o` rises with the strobe and stays high until the end of the gap. It is then low for at least one cycle, and both lines are low whenever `busy_o` is low.
- R11: The FIFO read data is captured in the cycle after the strobe, not in the strobe cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Allows new words to be fetched |
| fast_i | input | 1 | 1 selects FAST_DIV cycles per bit, 0 selects SLOW_DIV |
| short_gap_i | input | 1 | 1 selects SHORT_GAP bit times of quiet, 0 selects LONG_GAP |
| par_en_i | input | 1 | 1 replaces the top bit with parity |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| fifo_empty_i | input | 1 | FIFO has no word |
| fifo_data_i | input | WORD_W | Registered FIFO read data |
| fifo_rd_o | output | 1 | One-cycle FIFO read strobe |
| line_a_o | output | 1 | Positive return-to-zero line |
| line_b_o | output | 1 | Negative return-to-zero line |
| busy_o | output | 1 | High from the strobe until the end of the gap |

## Verification
The bench builds the block with FAST_DIV=4 and SLOW_DIV=10, and keeps the default gaps of 4 and 64 bit times. With these values both bit rates, the long gap and a change of speed in the middle of a word all fit into a few thousand cycles, while each half period is still more than one cycle long. The FIFO model in the bench holds a marker value until a strobe arrives. A design that samples the data in the wrong cycle therefore sends the wrong bits.

// File: rtl/rzt_pkg.sv
package rzt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_SEND,
    ST_GAP
  } rzt_state_e;
endpackage

// File: rtl/rzt_bit_timer.sv
module rzt_bit_timer #(
  parameter int FAST_DIV = 20,
  parameter int SLOW_DIV = 160
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic slow_i,
  output logic first_half_o,
  output logic bit_end_o
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CW = $clog2(MAX_DIV + 1);
  localparam logic [CW-1:0] FAST_L = CW'(FAST_DIV);
  localparam logic [CW-1:0] SLOW_L = CW'(SLOW_DIV);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] div_w;

  assign div_w        = slow_i ? SLOW_L : FAST_L;
  assign bit_end_o    = run_i && (cnt_q == div_w - CW'(1));
  assign first_half_o = run_i && (cnt_q < (div_w >> 1));

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      cnt_q <= '0;
    end else if (bit_end_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/rzt_word_fmt.sv
module rzt_word_fmt #(
  parameter int WORD_W  = 32,
  parameter int LABEL_W = 8
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic [WORD_W-1:0] tx_o
);
  function automatic logic fill_parity(input logic [WORD_W-2:0] body, input logic odd);
    return odd ? ~(^body) : (^body);
  endfunction

  logic [WORD_W-1:0] word_p;

  assign word_p = par_en_i ? {fill_parity(word_i[WORD_W-2:0], par_odd_i), word_i[WORD_W-2:0]}
                           : word_i;

  for (genvar k = 0; k < WORD_W; k++) begin : g_order
    if (k < LABEL_W) begin : g_label
      assign tx_o[k] = word_p[LABEL_W-1-k];
    end else begin : g_body
      assign tx_o[k] = word_p[k];
    end
  end
endmodule

// File: rtl/rz_word_tx.sv
module rz_word_tx
  import rzt_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int LABEL_W   = 8,
  parameter int FAST_DIV  = 20,
  parameter int SLOW_DIV  = 160,
  parameter int SHORT_GAP = 4,
  parameter int LONG_GAP  = 64
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic              fast_i,
  input  logic              short_gap_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  output logic              line_a_o,
  output logic              line_b_o,
  output logic              busy_o
);
  localparam int BW = $clog2(WORD_W);
  localparam int MAX_GAP = (LONG_GAP > SHORT_GAP) ? LONG_GAP : SHORT_GAP;
  localparam int GW = $clog2(MAX_GAP + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  rzt_state_e        state_q;
  logic [WORD_W-1:0] shreg_q;
  logic [BW-1:0]     bit_idx_q;
  logic [GW-1:0]     gap_idx_q;
  logic              slow_q;
  logic              short_q;

  logic [WORD_W-1:0] fmt_vec;
  logic              run_w;
  logic              first_half;
  logic              bit_end;
  logic              last_bit;
  logic              gap_last;
  logic [GW-1:0]     gap_len;

  rzt_word_fmt #(.WORD_W(WORD_W), .LABEL_W(LABEL_W)) i_fmt (
    .word_i   (fifo_data_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .tx_o     (fmt_vec)
  );

  assign run_w = (state_q == ST_SEND) || (state_q == ST_GAP);

  rzt_bit_timer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) i_timer (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .run_i       (run_w),
    .slow_i      (slow_q),
    .first_half_o(first_half),
    .bit_end_o   (bit_end)
  );

  assign gap_len  = short_q ? GW'(SHORT_GAP) : GW'(LONG_GAP);
  assign last_bit = (state_q == ST_SEND) && bit_end && (bit_idx_q == LAST_BIT);
  assign gap_last = (state_q == ST_GAP) && bit_end && (gap_idx_q == gap_len - GW'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= ST_IDLE;
      shreg_q   <= '0;
      bit_idx_q <= '0;
      gap_idx_q <= '0;
      slow_q    <= 1'b0;
      short_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (en_i && !fifo_empty_i) state_q <= ST_FETCH;
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          shreg_q   <= fmt_vec;
          slow_q    <= !fast_i;
          short_q   <= short_gap_i;
          bit_idx_q <= '0;
          state_q   <= ST_SEND;
        end
        ST_SEND: begin
          if (last_bit) begin
            gap_idx_q <= '0;
            state_q   <= ST_GAP;
          end else if (bit_end) begin
            bit_idx_q <= bit_idx_q + BW'(1);
            shreg_q   <= shreg_q >> 1;
          end
        end
        ST_GAP: begin
          if (gap_last) begin
            state_q <= ST_IDLE;
          end else if (bit_end) begin
            gap_idx_q <= gap_idx_q + GW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fifo_rd_o = (state_q == ST_FETCH);
  assign busy_o    = (state_q != ST_IDLE);
  assign line_a_o  = (state_q == ST_SEND) && first_half && shreg_q[0];
  assign line_b_o  = (state_q == ST_SEND) && first_half && !shreg_q[0];

  // R2
  rd_one_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fifo_rd_o |=> !fifo_rd_o);

  // R3
  rd_cond_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fifo_rd_o |-> $past(en_i && !fifo_empty_i));

  // R5
  lines_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(line_a_o && line_b_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> (!line_a_o && !line_b_o));

  // R9
  gap_end_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> $past(gap_last));
endmodule

// File: tb/test_rz_word_tx.sv
module test_rz_word_tx;
  localparam int FD = 4;
  localparam int SD = 10;
  localparam int SG = 4;
  localparam int LG = 64;

  typedef struct {
    logic [31:0] w;
    bit pe, po, slow, shortg;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  logic en = 0, fast = 1, short_gap = 1, par_en = 0, par_odd = 0;
  logic fifo_empty = 1;
  logic [31:0] fifo_data = 32'hDEAD_BEEF;
  logic rd, la, lb, busy;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int words_done = 0;

  logic [31:0] fq[$];
  exp_t eq[$];

  always #2 clk = ~clk;

  rz_word_tx #(.FAST_DIV(FD), .SLOW_DIV(SD), .SHORT_GAP(SG), .LONG_GAP(LG)) i_rz_word_tx (
    .clk_i(clk), .rst_i(rst), .en_i(en), .fast_i(fast), .short_gap_i(short_gap),
    .par_en_i(par_en), .par_odd_i(par_odd), .fifo_empty_i(fifo_empty),
    .fifo_data_i(fifo_data), .fifo_rd_o(rd), .line_a_o(la), .line_b_o(lb), .busy_o(busy)
  );

  // FIFO model with registered read data (R11: valid only after the strobe edge)
  always @(posedge clk) begin
    if (rd && fq.size() > 0) begin
      fifo_data <= fq.pop_front();
      fifo_empty <= (fq.size() == 0);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_seq(input exp_t e);
    logic [31:0] w = e.w;
    logic [31:0] s;
    bit even_cnt = ($countones(e.w[30:0]) % 2) == 0;
    if (e.pe) w[31] = e.po ? even_cnt : !even_cnt;
    for (int k = 0; k < 32; k++) s[k] = (k < 8) ? w[7-k] : w[k];
    return s;
  endfunction

  task automatic push_word(input logic [31:0] w);
    exp_t e;
    e.w = w; e.pe = par_en; e.po = par_odd; e.slow = !fast; e.shortg = short_gap;
    eq.push_back(e);
    fq.push_back(w);
    fifo_empty = 0;
    pushed++;
  endtask

  task automatic wait_done();
    while (words_done < pushed) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Scoreboard monitor
  initial begin
    exp_t e;
    logic [31:0] seq;
    int d, g;
    wait (!rst);
    forever begin
      @(negedge clk);
      if (rd) begin
        if (eq.size() == 0) begin
          check(0, "R2", 1, 0);
        end else begin
          e = eq.pop_front();
          seq = exp_seq(e);
          d = e.slow ? SD : FD;
          g = e.shortg ? SG : LG;
          @(negedge clk);
          // R2: strobe lasts one cycle
          check(!rd && busy && !la && !lb, "R2", {rd, busy, la, lb}, 32'b0100);
          for (int j = 0; j < 32; j++) begin
            for (int c = 0; c < d; c++) begin
              logic ea, eb;
              string tag;
              @(negedge clk);
              ea = (c < d/2) ? seq[j] : 1'b0;
              eb = (c < d/2) ? !seq[j] : 1'b0;
              if (j == 31) tag = e.pe ? "R7" : "R8";
              else if (j == 0 && c == 0) tag = "R11";
              else if (c == d-1) tag = "R6";
              else if (c < d/2) tag = "R4";
              else tag = "R5";
              check(la == ea && lb == eb && busy && !rd, tag,
                    {j[7:0], c[7:0], 5'b0, rd, busy, la, lb}, {j[7:0], c[7:0], 6'b0, 1'b1, ea, eb});
            end
          end
          for (int c = 0; c < g*d; c++) begin
            @(negedge clk);
            check(!la && !lb && busy && !rd, "R9", {c, rd, busy, la, lb}, {c, 4'b0100});
          end
          @(negedge clk);
          check(!busy && !la && !lb, "R10", {busy, la, lb}, 0);
          words_done++;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1
    repeat (4) @(negedge clk);
    check({rd, la, lb, busy} == 0, "R1", {rd, la, lb, busy}, 0);
    rst = 0;
    @(negedge clk);
    check({rd, la, lb, busy} == 0, "R1", {rd, la, lb, busy}, 0);

    // R3: enabled but empty
    en = 1;
    repeat (20) begin
      @(negedge clk);
      check({rd, la, lb, busy} == 0, "R3", {rd, la, lb, busy}, 0);
    end

    // R3: word waiting, enable low
    en = 0;
    push_word(32'hC3A5_0081);
    repeat (30) begin
      @(negedge clk);
      check({rd, la, lb, busy} == 0, "R3", {rd, la, lb, busy}, 0);
    end
    en = 1;
    wait_done();

    // R4 R5 R9: fast, short gap, no parity, back to back
    push_word(32'h8000_00C5);
    push_word(32'h1234_5601);
    push_word(32'hFFFF_FFFF);
    wait_done();

    // R7: odd parity
    par_en = 1; par_odd = 1;
    push_word(32'h0000_0001);
    push_word(32'h8000_0000);
    push_word(32'h7FFF_FFFF);
    wait_done();

    // R7: even parity
    par_odd = 0;
    push_word(32'h0000_0001);
    push_word(32'h8000_0000);
    push_word(32'h7FFF_FFFF);
    wait_done();

    // R8: parity off keeps top bit
    par_en = 0;
    push_word(32'hA000_0003);
    push_word(32'h0000_0002);
    wait_done();

    // R6 R9: slow rate, long gap
    fast = 0; short_gap = 0;
    push_word(32'h5A5A_A55A);
    wait_done();

    // R6: speed change during a word has no effect on it
    fast = 1; short_gap = 1;
    push_word(32'h0F0F_F0F0);
    while (!rd) @(negedge clk);
    repeat (2) @(negedge clk);
    fast = 0;
    wait_done();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule